// File: doc/BRIEF.md
# Three-Channel Serial ADC Poller

This block is an SPI master that keeps polling three single-ended inputs of a 12-bit serial converter. It keeps the newest result of each input in one 36-bit output word. It drives the serial clock, an active-high chip select and the command bits on MOSI, and it samples MISO. All of its activity runs on a tick that divides `clk_i` by `CLK_DIV`. The default of eight makes it a slow serial engine beside the system clock.

Frames overlap. During each 15-period frame the block sends the command for the next conversion. In the same frame the low half of the previous conversion arrives, and later the high half of the conversion just requested arrives. Each completed value is stored in the next output slot in rotation. A rising edge on `restart_i` is examined once per frame, at the last serial clock edge. When one is seen, the block inserts a one-tick restart state, resynchronises the converter by dropping chip select, and begins again from the first channel and the first slot. The first frame after any restart stores nothing.

Top module: `adc3_poller`

## Requirements
- R1: A tick occurs once every `CLK_DIV` cycles of `clk_i`, and `adc_sclk_o` changes only on a tick. Each serial period is one tick low followed by one tick high. A frame has 15 such periods. The high phase that contains the restart state lasts two ticks.
- R2: The command is placed on `adc_mosi_o` while `adc_sclk_o` is low, and it changes only then. During serial periods 1 to 8 the bits are 1 (start), A2, A1, A0, 0 (12-bit mode), 1 (single-ended), 0, 0 (power down between conversions). During periods 9 to 15 the bit is 0.
- R3: The (A2,A1,A0) address rotates frame by frame through 001, 101, 010 and then repeats. After a restart it begins again at 001.
- R4: Result bits 11 down to 6 are taken from `adc_miso_i` on rising serial edges 10 to 15 of a frame, MSB first. Bits 5 down to 0 are taken on rising edges 1 to 6 of the next frame. MISO on rising edges 7, 8 and 9 is ignored.
- R5: On rising edge 7 the assembled 12-bit value goes into one slot of `samples_o`. Slots are filled in the order 35:24, 23:12, 11:0, and then the order repeats.
- R6: No slot is written on rising edge 7 of the first frame after reset or restart. A slot keeps its value until it is written again.
- R7: At rising edge 15 the block samples `restart_i`. If that sample is 1 and the sample taken at the previous frame's edge 15 was 0, a restart state follows. A level held high causes no further restarts.
- R8: `adc_cs_o` is high throughout every frame. It is low for exactly one tick during a restart state, which is `CLK_DIV` cycles of `clk_i`.
- R9: While `rst_ni` is low, `adc_sclk_o`, `adc_cs_o`, `adc_mosi_o` and `samples_o` are 0. After release, the first tick is a restart state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Restart request, acted on at a rising edge |
| adc_miso_i | input | 1 | Serial data from the converter |
| adc_sclk_o | output | 1 | Serial clock |
| adc_cs_o | output | 1 | Chip select, active high |
| adc_mosi_o | output | 1 | Serial command to the converter |
| samples_o | output | 36 | Latest results, three 12-bit slots |

## Verification
The bench builds the block with `CLK_DIV` = 3 and the default address sequence. A divide ratio that is not a power of two checks that the tick counter wraps correctly and that every phase duration is an exact multiple of the ratio. The short frames that result allow about ninety frames per run. Those frames include back-to-back restarts, a held restart level and many full slot rotations. A converter model drives each result split across two frames and puts random bits on the ignored MISO edges.

// File: rtl/adc3_pkg.sv
package adc3_pkg;
  localparam int unsigned RES_W     = 12;
  localparam int unsigned NCH       = 3;
  localparam int unsigned AW        = 3;
  localparam int unsigned FRAME_LEN = 15;
  localparam int unsigned HALF      = RES_W / 2;
  localparam int unsigned LO_LAST   = HALF;
  localparam int unsigned WR_EDGE   = HALF + 1;
  localparam int unsigned HI_FIRST  = FRAME_LEN - HALF + 1;
  localparam int unsigned OUT_W     = NCH * RES_W;

  typedef logic [3:0]       edge_t;
  typedef logic [RES_W-1:0] res_t;
endpackage

// File: rtl/adc3_tick.sv
module adc3_tick #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  if (DIV <= 1) begin : g_nodiv
    assign tick_o = 1'b1;
  end else begin : g_div
    localparam int unsigned CW = $clog2(DIV);
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     cnt_q <= '0;
      else if (cnt_q == CW'(DIV - 1))  cnt_q <= '0;
      else                             cnt_q <= cnt_q + 1'b1;
    end
    assign tick_o = (cnt_q == CW'(DIV - 1));

    a_r1_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/adc3_addr.sv
module adc3_addr #(
  parameter int unsigned N  = 3,
  parameter int unsigned AW = 3,
  parameter logic [N*AW-1:0] INIT = 9'b001_101_010
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reload_i,
  input  logic          rotate_i,
  output logic [AW-1:0] cur_o
);
  localparam int unsigned TW = N * AW;
  logic [TW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= INIT;
    else if (reload_i) q <= INIT;
    else if (rotate_i) q <= {q[TW-AW-1:0], q[TW-1 -: AW]};
  end

  assign cur_o = q[TW-1 -: AW];

  a_r3_addr_weight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(q) == $countones(INIT));
endmodule

// File: rtl/adc3_slots.sv
module adc3_slots #(
  parameter int unsigned N = 3,
  parameter int unsigned W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           wr_i,
  input  logic [W-1:0]   data_i,
  output logic [N*W-1:0] dout_o
);
  localparam int unsigned PW = (N > 1) ? $clog2(N) : 1;
  logic [PW-1:0] ptr_q;
  logic [N-1:0]  wr_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (clr_i) ptr_q <= '0;
    else if (wr_i)  ptr_q <= (ptr_q == PW'(N - 1)) ? '0 : ptr_q + 1'b1;
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic [W-1:0] slot_q;
    assign wr_vec[i] = wr_i && (ptr_q == PW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        slot_q <= '0;
      else if (wr_vec[i]) slot_q <= data_i;
    end
    // slot 0 sits in the top bits
    assign dout_o[(N-1-i)*W +: W] = slot_q;
  end

  a_r5_one_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_vec));
  a_r5_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PW'(N - 1));
endmodule

// File: rtl/adc3_poller.sv
module adc3_poller
  import adc3_pkg::*;
#(
  parameter int unsigned CLK_DIV = 8,
  parameter logic [NCH*AW-1:0] ADDR_INIT = 9'b001_101_010
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             adc_miso_i,
  output logic             adc_sclk_o,
  output logic             adc_cs_o,
  output logic             adc_mosi_o,
  output logic [OUT_W-1:0] samples_o
);
  logic tick;
  logic pend_q, high_q, ready_q, hist_q;
  edge_t edge_q;
  logic [HALF-1:0] lo_q, hi_q;
  logic sclk_q, cs_q, mosi_q;
  logic [AW-1:0] addr;
  logic ctrl_bit;
  logic do_rst, fall, rise, wr;

  adc3_tick #(.DIV(CLK_DIV)) u_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  assign do_rst = tick && pend_q;
  assign fall   = tick && !pend_q && !high_q;
  assign rise   = tick && !pend_q && high_q;
  assign wr     = rise && (edge_q == edge_t'(WR_EDGE)) && ready_q;

  adc3_addr #(.N(NCH), .AW(AW), .INIT(ADDR_INIT)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reload_i(do_rst),
    .rotate_i(fall && (edge_q == edge_t'(4))),
    .cur_o   (addr)
  );

  adc3_slots #(.N(NCH), .W(RES_W)) u_slots (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (do_rst),
    .wr_i  (wr),
    .data_i({hi_q, lo_q}),
    .dout_o(samples_o)
  );

  // command bit for the serial period being started
  always_comb begin
    case (edge_q)
      edge_t'(1): ctrl_bit = 1'b1;
      edge_t'(2): ctrl_bit = addr[2];
      edge_t'(3): ctrl_bit = addr[1];
      edge_t'(4): ctrl_bit = addr[0];
      edge_t'(6): ctrl_bit = 1'b1;
      default:    ctrl_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b1;
      edge_q  <= edge_t'(1);
      high_q  <= 1'b0;
      ready_q <= 1'b0;
      hist_q  <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b0;
      mosi_q  <= 1'b0;
    end else if (do_rst) begin
      cs_q    <= 1'b0;
      ready_q <= 1'b0;
      pend_q  <= 1'b0;
      edge_q  <= edge_t'(1);
      high_q  <= 1'b0;
    end else if (fall) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      mosi_q <= ctrl_bit;
      high_q <= 1'b1;
    end else if (rise) begin
      sclk_q <= 1'b1;
      high_q <= 1'b0;
      if (edge_q <= edge_t'(LO_LAST))  lo_q <= {lo_q[HALF-2:0], adc_miso_i};
      if (edge_q >= edge_t'(HI_FIRST)) hi_q <= {hi_q[HALF-2:0], adc_miso_i};
      if (edge_q == edge_t'(WR_EDGE))  ready_q <= 1'b1;
      if (edge_q == edge_t'(FRAME_LEN)) begin
        hist_q <= restart_i;
        if (restart_i && !hist_q) pend_q <= 1'b1;
        edge_q <= edge_t'(1);
      end else begin
        edge_q <= edge_q + 4'd1;
      end
    end
  end

  assign adc_sclk_o = sclk_q;
  assign adc_cs_o   = cs_q;
  assign adc_mosi_o = mosi_q;

  a_r1_sclk_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(adc_sclk_o));
  a_r2_mosi_low_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(adc_mosi_o) |-> !adc_sclk_o);
  a_r8_cs_one_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adc_cs_o && tick && !pend_q) |=> adc_cs_o);
  a_r6_write_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(samples_o) |-> $rose(adc_sclk_o));
endmodule

// File: tb/adc3_poller_bench.sv
module adc3_poller_bench;
  localparam int unsigned DIV = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic restart_i = 1'b0;
  logic adc_miso_i = 1'b0;
  logic adc_sclk_o, adc_cs_o, adc_mosi_o;
  logic [35:0] samples_o;

  always #4 clk = ~clk;

  adc3_poller #(.CLK_DIV(DIV)) u_adc3_poller (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .restart_i (restart_i),
    .adc_miso_i(adc_miso_i),
    .adc_sclk_o(adc_sclk_o),
    .adc_cs_o  (adc_cs_o),
    .adc_mosi_o(adc_mosi_o),
    .samples_o (samples_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [35:0] act,
                     input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_mosi(input int e, input int ch);
    logic [2:0] a;
    a = (ch == 0) ? 3'b001 : (ch == 1) ? 3'b101 : 3'b010;
    case (e)
      1: return 1'b1;
      2: return a[2];
      3: return a[1];
      4: return a[0];
      6: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [11:0] pick_value(input int f);
    case (f)
      0: return 12'hFFF;
      1: return 12'h000;
      2: return 12'hA5A;
      3: return 12'h001;
      4: return 12'h800;
      default: return 12'($urandom);
    endcase
  endfunction

  initial begin
    int k, ch, ptr, set_for, frames, cyc, dur, cs_low_cnt;
    bit first, pred_reset, saw_cs_low, hist, prev_sc, sc, first_lo, first_cs;
    bit hi_had_rst, timeout;
    logic [11:0] cur_v, prev_v;
    logic [35:0] exp_dout;

    void'($urandom(32'd4711));
    k = 0; ch = 0; ptr = 0; set_for = -1; frames = 0; cyc = 0; dur = 0;
    cs_low_cnt = 0; first = 1; pred_reset = 1; saw_cs_low = 0; hist = 0;
    prev_sc = 0; first_lo = 1; first_cs = 1; hi_had_rst = 0; timeout = 0;
    cur_v = 12'h0; prev_v = 12'h0; exp_dout = '0;

    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(adc_sclk_o == 1'b0, "R9 sclk in reset", 36'(adc_sclk_o), 36'h0);
    chk(adc_cs_o == 1'b0, "R9 cs in reset", 36'(adc_cs_o), 36'h0);
    chk(adc_mosi_o == 1'b0, "R9 mosi in reset", 36'(adc_mosi_o), 36'h0);
    chk(samples_o == 36'h0, "R9 samples in reset", samples_o, 36'h0);
    rst_ni = 1'b1;

    while (frames < 90 && !timeout) begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) timeout = 1;
      sc = adc_sclk_o;

      if (!adc_cs_o) begin
        cs_low_cnt++;
        saw_cs_low = 1;
        if (sc) hi_had_rst = 1;
        k = 0; ch = 0; ptr = 0; first = 1; set_for = -1;
      end else if (cs_low_cnt > 0) begin
        if (!first_cs)
          chk(cs_low_cnt == DIV, "R8 cs low width", 36'(cs_low_cnt), 36'(DIV));
        first_cs = 0;
        cs_low_cnt = 0;
      end

      dur++;
      if (sc != prev_sc) begin
        if (sc) begin
          if (!first_lo) chk(dur == DIV, "R1 low half", 36'(dur), 36'(DIV));
          first_lo = 0;
          hi_had_rst = 0;
          k++;
          chk(adc_mosi_o == exp_mosi(k, ch), (k >= 2 && k <= 4) ? "R3 address bit" : "R2 command bit",
              36'(adc_mosi_o), 36'(exp_mosi(k, ch)));
          if (k == 1) begin
            chk(saw_cs_low == pred_reset, "R7 restart taken", 36'(saw_cs_low), 36'(pred_reset));
            saw_cs_low = 0;
          end
          if (k == 7) begin
            if (!first) begin
              exp_dout[(2-ptr)*12 +: 12] = prev_v;
              ptr = (ptr + 1) % 3;
              chk(samples_o == exp_dout, "R4 R5 slot write", samples_o, exp_dout);
            end else begin
              chk(samples_o == exp_dout, "R6 first frame no write", samples_o, exp_dout);
            end
            first = 0;
          end else begin
            chk(samples_o == exp_dout, "R6 hold", samples_o, exp_dout);
          end
          if (k == 5) begin
            case (frames)
              8:  restart_i = 1'b1;
              12: restart_i = 1'b0;
              13: restart_i = 1'b1;
              14: restart_i = 1'b0;
              15: restart_i = 1'b1;
              default: if (frames > 30 && ($urandom % 4) == 0) restart_i = ~restart_i;
            endcase
          end
          if (k == 15) begin
            pred_reset = restart_i && !hist;
            hist = restart_i;
            k = 0;
            ch = (ch + 1) % 3;
            frames++;
          end
        end else begin
          chk(dur == (hi_had_rst ? 2 * DIV : DIV), "R1 high half", 36'(dur),
              36'(hi_had_rst ? 2 * DIV : DIV));
          hi_had_rst = 0;
        end
        dur = 0;
      end
      prev_sc = sc;

      // converter model: present MISO for the next rising edge
      if (!sc && set_for != k + 1) begin
        set_for = k + 1;
        if (set_for == 1) begin
          prev_v = cur_v;
          cur_v = pick_value(frames);
        end
        if (set_for >= 1 && set_for <= 6)        adc_miso_i = prev_v[6 - set_for];
        else if (set_for >= 10 && set_for <= 15) adc_miso_i = cur_v[21 - set_for];
        else                                     adc_miso_i = 1'($urandom);
      end
    end

    if (timeout) begin
      n_bad++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", frames, 90);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule